// File: doc/BRIEF.md
# Ethernet PHY Status LED Driver

This block decides the state of the three status lamps beside a 10/100 twisted-pair port: one shows that the link is up, one shows that the port runs at 100 Mbps, and one blinks while packets move. It sits next to the PHY's link and speed logic and the packet path. It takes a link flag and a speed flag. It also takes single-cycle strobes for each sent or received packet, each tagged with a two-bit class. The lamp outputs go straight to the pad drivers. All three outputs are active low.

Traffic is shown by a pulse-stretch timer. A qualifying packet lights the activity lamp for a fixed number of cycles. A fixed dark gap of cycles then follows. A packet that arrives while the lamp is lit or dark is remembered and served as soon as the gap ends. Sparse traffic therefore gives short isolated flashes. Heavy traffic gives a steady blink, never a solid glow. When the wake-on-LAN flag is set, a configuration bit narrows which packet classes may start a flash.

Top module: `phy_led_status`

## Requirements
- R1: All three lamp outputs are active low (0 = lamp on). While the synchronous reset `rst` is sampled high at a clock edge, all three outputs read 1 after that edge, whatever the other inputs are.
- R2: `link_led_n` reads 0 after the first clock edge that samples `link_up` = 1, and reads 1 after the first edge that samples `link_up` = 0. Speed has no effect on it.
- R3: `spd_led_n` reads 0 after an edge that samples `link_up` = 1 and `speed_100` = 1. It reads 1 after an edge that samples `speed_100` = 0 or `link_up` = 0.
- R4: With `wol_mode` = 0, any transmit or receive strobe lights `act_led_n` (0) after the edge that samples it, provided the link is up and the timer is idle. This holds for every class value.
- R5: Class encoding is 2'b00 other, 2'b01 broadcast, 2'b10 individual-address match, 2'b11 other. With `wol_mode` = 1 and `wol_ucast_only` = 0, only class 2'b01 or 2'b10 strobes start a flash. Strobes of class 2'b00 or 2'b11 leave `act_led_n` at 1.
- R6: With `wol_mode` = 1 and `wol_ucast_only` = 1, only class 2'b10 strobes start a flash. Broadcast and other classes leave `act_led_n` at 1.
- R7: A flash keeps `act_led_n` at 0 for exactly ON_CYC cycles. Then `act_led_n` stays at 1 for at least OFF_CYC cycles.
- R8: A qualifying strobe that arrives during the lit time or the dark gap is remembered. It starts the next flash on the edge that ends the gap. A strobe held high continuously therefore gives a blink with period ON_CYC + OFF_CYC.
- R9: An edge that samples `link_up` = 0 clears the timer and any remembered strobe. `act_led_n` and `spd_led_n` then read 1 after that edge. Strobes sampled while the link is down have no effect, even after the link returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| link_up | input | 1 | Link present |
| speed_100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| tx_stb | input | 1 | One-cycle strobe per transmitted packet |
| tx_cls | input | 2 | Class of the transmitted packet |
| rx_stb | input | 1 | One-cycle strobe per received packet |
| rx_cls | input | 2 | Class of the received packet |
| wol_mode | input | 1 | Wake-on-LAN mode active |
| wol_ucast_only | input | 1 | In wake-on-LAN mode, only address-match packets flash |
| link_led_n | output | 1 | Link lamp, active low |
| act_led_n | output | 1 | Activity lamp, active low |
| spd_led_n | output | 1 | Speed lamp, active low |

## Verification
Every lamp output comes from a register. Each result is therefore due one clock edge after the inputs that cause it: link and speed flags, a qualifying strobe on an idle timer, and a link drop. The bench drives inputs on the falling edge and samples on the next falling edge, so the check falls right after the edge concerned. For the blink timing, the bench samples on every falling edge through a full window. It expects lit for samples 0 to ON_CYC-1 and dark up to ON_CYC+OFF_CYC-1. A remembered strobe relights the lamp at sample ON_CYC+OFF_CYC. Between table vectors, the bench waits longer than one full flash so that each vector starts from an idle timer.

// File: rtl/led_pkg.sv
package led_pkg;

    typedef enum logic [1:0] {
        CLS_OTHER = 2'b00,
        CLS_BCAST = 2'b01,
        CLS_UCAST = 2'b10,
        CLS_SPARE = 2'b11
    } pkt_cls_e;

    typedef enum logic [1:0] {
        BLK_IDLE = 2'b00,
        BLK_LIT  = 2'b01,
        BLK_GAP  = 2'b10
    } blink_st_e;

    localparam int unsigned NUM_PORTS = 2;

endpackage

// File: rtl/pkt_gate.sv
module pkt_gate
    import led_pkg::*;
(
    input  logic     stb,
    input  pkt_cls_e cls,
    input  logic     wol_mode,
    input  logic     wol_ucast_only,
    output logic     hit
);

    logic class_ok;

    always_comb begin
        if (!wol_mode) begin
            class_ok = 1'b1;
        end else if (wol_ucast_only) begin
            class_ok = (cls == CLS_UCAST);
        end else begin
            class_ok = (cls == CLS_UCAST) || (cls == CLS_BCAST);
        end
        hit = stb && class_ok;
    end

endmodule

// File: rtl/blink_timer.sv
module blink_timer
    import led_pkg::*;
#(
    parameter int unsigned ON_CYC  = 4,
    parameter int unsigned OFF_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic trig,
    output logic lit,
    output logic busy
);

    localparam int unsigned MAX_CYC = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
    localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_CYC - 1);
    localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_CYC - 1);

    typedef struct packed {
        blink_st_e        st;
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } blink_s;

    blink_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.st)
            BLK_IDLE: begin
                if (trig) begin
                    st_d.st  = BLK_LIT;
                    st_d.cnt = ON_LAST;
                end
            end
            BLK_LIT: begin
                st_d.pend = st_q.pend | trig;
                if (st_q.cnt == '0) begin
                    st_d.st  = BLK_GAP;
                    st_d.cnt = OFF_LAST;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            BLK_GAP: begin
                if (st_q.cnt == '0) begin
                    if (st_q.pend || trig) begin
                        st_d.st  = BLK_LIT;
                        st_d.cnt = ON_LAST;
                    end else begin
                        st_d.st  = BLK_IDLE;
                        st_d.cnt = '0;
                    end
                    st_d.pend = 1'b0;
                end else begin
                    st_d.cnt  = st_q.cnt - CNT_W'(1);
                    st_d.pend = st_q.pend | trig;
                end
            end
            default: begin
                st_d = '{st: BLK_IDLE, cnt: '0, pend: 1'b0};
            end
        endcase
        if (!en) begin
            st_d = '{st: BLK_IDLE, cnt: '0, pend: 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{st: BLK_IDLE, cnt: '0, pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lit  = (st_q.st == BLK_LIT);
    assign busy = (st_q.st != BLK_IDLE);

    // R7: the lit phase ends in the dark gap, never straight in a new flash
    assert_lit_then_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q.st == BLK_LIT && st_q.cnt == '0 && en) |=> (st_q.st == BLK_GAP));

    // R7: while gap cycles remain, the lamp stays dark
    assert_gap_dark_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q.st == BLK_GAP && st_q.cnt != '0 && en) |=> !lit);

    // R8: a remembered strobe relights the lamp when the gap ends
    assert_pend_served_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q.st == BLK_GAP && st_q.cnt == '0 && st_q.pend && en) |=> lit);

    // R9: link loss empties the timer
    assert_link_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st_q.st == BLK_IDLE && !st_q.pend));

endmodule

// File: rtl/phy_led_status.sv
module phy_led_status
    import led_pkg::*;
#(
    parameter int unsigned ON_CYC  = 4,
    parameter int unsigned OFF_CYC = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       link_up,
    input  logic       speed_100,
    input  logic       tx_stb,
    input  logic [1:0] tx_cls,
    input  logic       rx_stb,
    input  logic [1:0] rx_cls,
    input  logic       wol_mode,
    input  logic       wol_ucast_only,
    output logic       link_led_n,
    output logic       act_led_n,
    output logic       spd_led_n
);

    typedef struct packed {
        logic link_n;
        logic spd_n;
    } lamp_s;

    lamp_s lamp_d, lamp_q;

    logic     [NUM_PORTS-1:0] stb_v;
    pkt_cls_e                 cls_v [NUM_PORTS];
    logic     [NUM_PORTS-1:0] hit_v;
    logic                     trig;
    logic                     act_lit;
    logic                     act_busy;

    assign stb_v    = {rx_stb, tx_stb};
    assign cls_v[0] = pkt_cls_e'(tx_cls);
    assign cls_v[1] = pkt_cls_e'(rx_cls);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_gate
        pkt_gate u_gate (
            .stb            (stb_v[p]),
            .cls            (cls_v[p]),
            .wol_mode       (wol_mode),
            .wol_ucast_only (wol_ucast_only),
            .hit            (hit_v[p])
        );
    end

    assign trig = link_up && (|hit_v);

    blink_timer #(
        .ON_CYC  (ON_CYC),
        .OFF_CYC (OFF_CYC)
    ) u_blink (
        .clk  (clk),
        .rst  (rst),
        .en   (link_up),
        .trig (trig),
        .lit  (act_lit),
        .busy (act_busy)
    );

    always_comb begin
        lamp_d        = lamp_q;
        lamp_d.link_n = ~link_up;
        lamp_d.spd_n  = ~(link_up & speed_100);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lamp_q <= '{link_n: 1'b1, spd_n: 1'b1};
        end else begin
            lamp_q <= lamp_d;
        end
    end

    assign link_led_n = lamp_q.link_n;
    assign spd_led_n  = lamp_q.spd_n;
    assign act_led_n  = ~act_lit;

    assert_reset_dark_R1: assert property (@(posedge clk)
        rst |=> (link_led_n && act_led_n && spd_led_n));

    assert_link_on_R2: assert property (@(posedge clk) disable iff (rst)
        link_up |=> !link_led_n);

    assert_spd_follow_R3: assert property (@(posedge clk) disable iff (rst)
        (link_up && speed_100) |=> !spd_led_n);

    assert_spd_ten_R3: assert property (@(posedge clk) disable iff (rst)
        !speed_100 |=> spd_led_n);

    assert_any_class_R4: assert property (@(posedge clk) disable iff (rst)
        (link_up && !act_busy && !wol_mode && (tx_stb || rx_stb)) |=> !act_led_n);

    assert_ucast_only_R6: assert property (@(posedge clk) disable iff (rst)
        (link_up && !act_busy && wol_mode && wol_ucast_only
         && !(tx_stb && tx_cls == 2'b10) && !(rx_stb && rx_cls == 2'b10)) |=> act_led_n);

    assert_link_drop_R9: assert property (@(posedge clk) disable iff (rst)
        !link_up |=> (act_led_n && spd_led_n && link_led_n));

endmodule

// File: tb/phy_led_status_tb_top.sv
module phy_led_status_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ON_C       = 4;
    localparam int OFF_C      = 3;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       link_up = 1'b0;
    logic       speed_100 = 1'b0;
    logic       tx_stb = 1'b0;
    logic [1:0] tx_cls = 2'b00;
    logic       rx_stb = 1'b0;
    logic [1:0] rx_cls = 2'b00;
    logic       wol_mode = 1'b0;
    logic       wol_ucast_only = 1'b0;
    logic       link_led_n;
    logic       act_led_n;
    logic       spd_led_n;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_led_status #(.ON_CYC(ON_C), .OFF_CYC(OFF_C)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .link_up        (link_up),
        .speed_100      (speed_100),
        .tx_stb         (tx_stb),
        .tx_cls         (tx_cls),
        .rx_stb         (rx_stb),
        .rx_cls         (rx_cls),
        .wol_mode       (wol_mode),
        .wol_ucast_only (wol_ucast_only),
        .link_led_n     (link_led_n),
        .act_led_n      (act_led_n),
        .spd_led_n      (spd_led_n)
    );

    // {wol, ucast_only, tx_stb, tx_cls[1:0], rx_stb, rx_cls[1:0], expect_lit}
    localparam int NVEC = 12;
    localparam logic [8:0] VEC [NVEC] = '{
        9'b0_0_1_00_0_00_1,
        9'b0_1_0_00_1_11_1,
        9'b1_0_1_01_0_00_1,
        9'b1_0_0_00_1_10_1,
        9'b1_0_1_00_0_00_0,
        9'b1_0_0_00_1_11_0,
        9'b1_1_1_10_0_00_1,
        9'b1_1_1_01_0_00_0,
        9'b1_1_1_00_1_01_0,
        9'b1_1_1_00_1_10_1,
        9'b1_0_0_00_0_00_0,
        9'b0_0_1_01_1_10_1
    };

    task automatic check(input logic actual, input logic expected, input string tag);
        n_tests++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, actual, expected);
        end
    endtask

    task automatic settle();
        tx_stb = 1'b0;
        rx_stb = 1'b0;
        repeat (ON_C + OFF_C + 3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        // R1: reset dominates live inputs
        link_up = 1'b1; speed_100 = 1'b1; tx_stb = 1'b1;
        repeat (3) @(negedge clk);
        check(link_led_n, 1'b1, "R1 link lamp in reset");
        check(act_led_n,  1'b1, "R1 activity lamp in reset");
        check(spd_led_n,  1'b1, "R1 speed lamp in reset");
        tx_stb = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check(link_led_n, 1'b0, "R2 link lamp on");
        check(spd_led_n,  1'b0, "R3 speed lamp at 100");
        speed_100 = 1'b0;
        @(negedge clk);
        check(spd_led_n,  1'b1, "R3 speed lamp at 10");
        check(link_led_n, 1'b0, "R2 link lamp ignores speed");
        settle();

        // R4 R5 R6: class table
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            tag = VEC[v][8] ? (VEC[v][7] ? "R6 class filter" : "R5 class filter") : "R4 any class";
            wol_mode       = VEC[v][8];
            wol_ucast_only = VEC[v][7];
            tx_stb         = VEC[v][6];
            tx_cls         = VEC[v][5:4];
            rx_stb         = VEC[v][3];
            rx_cls         = VEC[v][2:1];
            @(negedge clk);
            tx_stb = 1'b0;
            rx_stb = 1'b0;
            check(act_led_n, ~VEC[v][0], tag);
            settle();
        end
        wol_mode = 1'b0;
        wol_ucast_only = 1'b0;

        // R7 R8: flash window with one remembered strobe
        tx_stb = 1'b1;
        @(negedge clk);
        tx_stb = 1'b0;
        for (int i = 0; i < ON_C + OFF_C + 3; i++) begin
            logic exp_lit;
            exp_lit = (i < ON_C) || (i >= ON_C + OFF_C);
            check(act_led_n, ~exp_lit, (i < ON_C + OFF_C) ? "R7 flash window" : "R8 remembered strobe");
            tx_stb = (i == 1);
            @(negedge clk);
        end
        tx_stb = 1'b0;
        settle();
        settle();

        // R8: continuous traffic blinks
        rx_stb = 1'b1;
        rx_cls = 2'b00;
        for (int i = 0; i < 3 * (ON_C + OFF_C); i++) begin
            @(negedge clk);
            check(act_led_n, ~((i % (ON_C + OFF_C)) < ON_C), "R8 steady blink");
        end
        rx_stb = 1'b0;
        settle();
        settle();

        // R9: link drop mid-flash with a pending strobe
        speed_100 = 1'b1;
        tx_stb = 1'b1;
        @(negedge clk);
        check(act_led_n, 1'b0, "R9 flash before drop");
        check(spd_led_n, 1'b0, "R3 speed lamp before drop");
        link_up = 1'b0;
        @(negedge clk);
        check(act_led_n,  1'b1, "R9 activity off after drop");
        check(spd_led_n,  1'b1, "R9 speed off after drop");
        check(link_led_n, 1'b1, "R2 link lamp off");
        @(negedge clk);
        tx_stb = 1'b0;
        link_up = 1'b1;
        for (int i = 0; i < ON_C + OFF_C + 2; i++) begin
            @(negedge clk);
            check(act_led_n, 1'b1, "R9 nothing remembered across drop");
        end
        check(spd_led_n, 1'b0, "R3 speed lamp after relink");

        finish_run();
    end

endmodule